// File: doc/BRIEF.md
# Consecutive-Frame Persistence Filter

This block filters a per-frame status value so that downstream logic sees a change only once the new value has settled. On every frame strobe it takes a candidate value and a flag saying whether that frame's framing bytes were damaged. It keeps a run count of consecutive clean frames that carried the same candidate. When the run reaches a programmable threshold, it moves the candidate into the accepted output and raises a single-cycle change pulse.

A damaged frame breaks the run. A different candidate starts a new run at one. A threshold programmed as zero acts as a threshold of one. Cycles without a strobe are idle and leave all state untouched. The block is placed after whatever logic extracts the monitored byte from each frame.

Top module: `persist_filter`

## Requirements
- R1: A synchronous, active-high reset clears the accepted value to zero, holds the change pulse low and empties the run count. After reset, a nonzero value is accepted only after a full run of qualifying frames.
- R2: With an effective threshold N, a candidate that differs from the accepted value is accepted on the N-th consecutive clean frame that carries it, and not on any earlier frame.
- R3: A strobed frame whose framing-error flag is high clears the run count to zero and never updates the accepted value. The next clean frame starts a new run of one.
- R4: A clean frame whose candidate differs from the candidate of the current run restarts the run at one, counting that frame.
- R5: The threshold input is 4 bits wide (1 to 15). The value 0 behaves exactly like 1, so every clean frame with a new candidate is accepted at once.
- R6: A candidate equal to the accepted value never produces a change pulse and leaves the accepted value unchanged, however long its run grows.
- R7: The accepted value and the change pulse both update on the first clock edge after the accepting strobe. The pulse is high for exactly those cycles in which the accepted value has just changed.
- R8: In cycles without a strobe, the candidate and error inputs have no effect on the run count, the accepted value or the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-cycle strobe marking a frame's sample |
| cand_val | input | DATA_W | Candidate status value for this frame |
| frame_err | input | 1 | Framing bytes of this frame were in error |
| thresh | input | 4 | Required consecutive-frame count (0 treated as 1) |
| acc_val | output | DATA_W | Accepted (validated) status value |
| chg_pulse | output | 1 | High for one cycle when acc_val has just changed |

## Verification
Two events can land on the same frame: the frame that would complete a run, and either a framing error or a candidate change. The framing error must win and cancel the update. The candidate change must restart the count instead of completing it. The bench provokes both for every threshold from 2 to 15, placing the error at each position in the run, including the final frame. It then judges the outcome by requiring the pulse exactly N clean frames after the disturbance, as computed from the threshold.

// File: rtl/pf_pkg.sv
package pf_pkg;
    localparam int unsigned THR_W   = 4;
    localparam int unsigned CNT_MAX = (1 << THR_W) - 1;

    typedef logic [THR_W-1:0] thr_t;

    // classification of one clock cycle from the filter's point of view
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,   // no strobe
        EV_ERR  = 2'd1,   // strobe with damaged framing
        EV_NEW  = 2'd2,   // clean strobe starting a new run
        EV_SAME = 2'd3    // clean strobe extending the current run
    } frame_ev_e;
endpackage

// File: rtl/pf_thresh_clamp.sv
module pf_thresh_clamp
    import pf_pkg::*;
(
    input  thr_t thr_in,
    output thr_t thr_eff
);
    localparam thr_t THR_MIN = thr_t'(1);

    always_comb begin
        if (thr_in < THR_MIN) begin
            thr_eff = THR_MIN;
        end else begin
            thr_eff = thr_in;
        end
    end
endmodule

// File: rtl/pf_frame_class.sv
module pf_frame_class
    import pf_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              stb,
    input  logic              err,
    input  logic [DATA_W-1:0] cand,
    input  logic [DATA_W-1:0] run_val,
    input  logic              run_empty,
    output frame_ev_e         ev
);
    always_comb begin
        if (!stb) begin
            ev = EV_NONE;
        end else if (err) begin
            ev = EV_ERR;
        end else if (run_empty || (cand != run_val)) begin
            ev = EV_NEW;
        end else begin
            ev = EV_SAME;
        end
    end
endmodule

// File: rtl/pf_run_tracker.sv
module pf_run_tracker
    import pf_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  frame_ev_e         ev,
    input  logic [DATA_W-1:0] cand,
    output logic [DATA_W-1:0] run_val,
    output logic              run_empty,
    output thr_t              cnt_next
);
    localparam thr_t CNT_TOP = thr_t'(CNT_MAX);

    typedef struct packed {
        logic [DATA_W-1:0] run;
        thr_t              cnt;
    } run_st_t;

    run_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (ev)
            EV_ERR: begin
                st_d.cnt = '0;
            end
            EV_NEW: begin
                st_d.run = cand;
                st_d.cnt = thr_t'(1);
            end
            EV_SAME: begin
                if (st_q.cnt != CNT_TOP) begin
                    st_d.cnt = st_q.cnt + thr_t'(1);
                end
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_val   = st_q.run;
    assign run_empty = (st_q.cnt == '0);
    assign cnt_next  = st_d.cnt;
endmodule

// File: rtl/pf_accept.sv
module pf_accept
    import pf_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  frame_ev_e         ev,
    input  thr_t              cnt_next,
    input  thr_t              thr_eff,
    input  logic [DATA_W-1:0] cand,
    output logic [DATA_W-1:0] acc_val,
    output logic              chg
);
    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              chg;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic    clean_frame;
    logic    run_full;
    logic    is_new_val;

    always_comb begin
        clean_frame = (ev == EV_NEW) || (ev == EV_SAME);
        run_full    = (cnt_next >= thr_eff);
        is_new_val  = (cand != st_q.acc);
        st_d        = st_q;
        st_d.chg    = 1'b0;
        if (clean_frame && run_full && is_new_val) begin
            st_d.acc = cand;
            st_d.chg = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_val = st_q.acc;
    assign chg     = st_q.chg;
endmodule

// File: rtl/persist_filter.sv
module persist_filter
    import pf_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_stb,
    input  logic [DATA_W-1:0] cand_val,
    input  logic              frame_err,
    input  logic [THR_W-1:0]  thresh,
    output logic [DATA_W-1:0] acc_val,
    output logic              chg_pulse
);
    thr_t              thr_eff;
    frame_ev_e         ev;
    logic [DATA_W-1:0] run_val;
    logic              run_empty;
    thr_t              cnt_next;

    pf_thresh_clamp u_clamp (
        .thr_in  (thresh),
        .thr_eff (thr_eff)
    );

    pf_frame_class #(.DATA_W(DATA_W)) u_class (
        .stb       (frame_stb),
        .err       (frame_err),
        .cand      (cand_val),
        .run_val   (run_val),
        .run_empty (run_empty),
        .ev        (ev)
    );

    pf_run_tracker #(.DATA_W(DATA_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .cand      (cand_val),
        .run_val   (run_val),
        .run_empty (run_empty),
        .cnt_next  (cnt_next)
    );

    pf_accept #(.DATA_W(DATA_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .cnt_next (cnt_next),
        .thr_eff  (thr_eff),
        .cand     (cand_val),
        .acc_val  (acc_val),
        .chg      (chg_pulse)
    );
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_stb,
    input logic [DATA_W-1:0] cand_val,
    input logic              frame_err,
    input logic [3:0]        thresh,
    input logic [DATA_W-1:0] acc_val,
    input logic              chg_pulse
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b1;
        end else begin
            armed <= armed;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (acc_val == '0) && !chg_pulse);

    // R3
    err_no_update_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (frame_stb && frame_err) |=> !chg_pulse && $stable(acc_val));

    // R5
    low_thresh_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (frame_stb && !frame_err && (thresh <= 4'd1) && (cand_val != acc_val))
        |=> chg_pulse && (acc_val == $past(cand_val)));

    // R6
    same_val_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (frame_stb && (cand_val == acc_val)) |=> !chg_pulse);

    // R7
    pulse_means_change_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        chg_pulse |-> (acc_val != $past(acc_val)));

    // R7
    change_means_pulse_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (acc_val != $past(acc_val)) |-> chg_pulse);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        !frame_stb |=> !chg_pulse && $stable(acc_val));
endmodule

bind persist_filter pf_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_stb (frame_stb),
    .cand_val  (cand_val),
    .frame_err (frame_err),
    .thresh    (thresh),
    .acc_val   (acc_val),
    .chg_pulse (chg_pulse)
);

// File: tb/persist_filter_tb.sv
`timescale 1ns/1ps
module persist_filter_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         frame_stb = 1'b0;
    logic [W-1:0] cand_val = '0;
    logic         frame_err = 1'b0;
    logic [3:0]   thresh = 4'd1;
    logic [W-1:0] acc_val;
    logic         chg_pulse;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference state derived from the requirements
    logic [W-1:0] m_run;
    int           m_cnt;
    logic [W-1:0] m_acc;

    persist_filter #(.DATA_W(W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .cand_val  (cand_val),
        .frame_err (frame_err),
        .thresh    (thresh),
        .acc_val   (acc_val),
        .chg_pulse (chg_pulse)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= 200000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 200000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        frame_stb = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_run = '0;
        m_cnt = 0;
        m_acc = '0;
        chk("R1", "acc after reset", int'(acc_val), 0);
        chk("R1", "pulse after reset", int'(chg_pulse), 0);
    endtask

    task automatic frame(input logic [W-1:0] v, input logic e, input string req);
        int  neff;
        int  exp_chg;
        neff = (thresh == 4'd0) ? 1 : int'(thresh);
        exp_chg = 0;
        if (e) begin
            m_cnt = 0;
        end else begin
            if (m_cnt == 0 || v != m_run) begin
                m_run = v;
                m_cnt = 1;
            end else if (m_cnt < 15) begin
                m_cnt = m_cnt + 1;
            end
            if (m_cnt >= neff && v != m_acc) begin
                m_acc = v;
                exp_chg = 1;
            end
        end
        @(negedge clk);
        frame_stb = 1'b1;
        cand_val  = v;
        frame_err = e;
        @(negedge clk);
        frame_stb = 1'b0;
        cand_val  = ~v;
        frame_err = ~e;
        chk(req, "pulse", int'(chg_pulse), exp_chg);
        chk(req, "acc", int'(acc_val), int'(m_acc));
    endtask

    task automatic idle(input int n);
        logic [W-1:0] held;
        held = acc_val;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cand_val  = W'(i * 37 + 11);
            frame_err = i[0];
            chk("R8", "idle pulse", int'(chg_pulse), 0);
            chk("R8", "idle acc", int'(acc_val), int'(held));
        end
    endtask

    initial begin
        do_reset();

        // R2 / R5: plain runs for every threshold
        for (int n = 0; n < 16; n++) begin
            thresh = 4'(n);
            do_reset();
            for (int i = 0; i < 17; i++) begin
                frame(8'h5A, 1'b0, (n == 0) ? "R5" : "R2");
            end
            chk("R2", "accepted after long run", int'(acc_val), 8'h5A);
            // a second value right after, R6 holds on the old one meanwhile
            for (int i = 0; i < n + 1; i++) frame(8'hC3, 1'b0, "R2");
        end

        // R3: error at every position of a run, including the last frame
        for (int n = 2; n < 16; n++) begin
            for (int p = 1; p < n; p++) begin
                thresh = 4'(n);
                do_reset();
                for (int i = 0; i < p; i++) frame(8'h21, 1'b0, "R3");
                frame(8'h21, 1'b1, "R3");
                for (int i = 0; i < n; i++) frame(8'h21, 1'b0, "R3");
                chk("R3", "accepted N frames after error", int'(acc_val), 8'h21);
            end
        end

        // R4: candidate change on the would-be completing frame
        for (int n = 2; n < 16; n++) begin
            thresh = 4'(n);
            do_reset();
            for (int i = 0; i < n - 1; i++) frame(8'h44, 1'b0, "R4");
            for (int i = 0; i < n; i++) frame(8'h77, 1'b0, "R4");
            chk("R4", "new run accepted", int'(acc_val), 8'h77);
            for (int i = 0; i < 2 * n; i++) frame(i[0] ? 8'h10 : 8'h20, 1'b0, "R4");
            chk("R4", "alternation rejected", int'(acc_val), 8'h77);
        end

        // R6: candidate equals accepted value (including zero after reset)
        thresh = 4'd3;
        do_reset();
        for (int i = 0; i < 20; i++) frame(8'h00, 1'b0, "R6");
        for (int i = 0; i < 3; i++) frame(8'h99, 1'b0, "R6");
        for (int i = 0; i < 25; i++) frame(8'h99, 1'b0, "R6");

        // R7 / R8: back-to-back acceptance with thresh 1, idle gaps with junk
        thresh = 4'd1;
        do_reset();
        for (int i = 0; i < 8; i++) frame(W'(i + 1), 1'b0, "R7");
        idle(6);
        thresh = 4'd4;
        frame(8'hE0, 1'b0, "R8");
        idle(5);
        frame(8'hE0, 1'b0, "R8");
        idle(3);
        frame(8'hE0, 1'b0, "R8");
        idle(2);
        frame(8'hE0, 1'b0, "R8");
        chk("R8", "run survives idle gaps", int'(acc_val), 8'hE0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule